// File: doc/BRIEF.md
# ATA Device Task File Register Block

This block is the device-side register file of a parallel ATA target. On every host read or write strobe it decodes the two active-low chip selects and the three register address lines. It then reads or updates one register of the command block or the control block. Register traffic uses only an 8-bit byte lane. The 16-bit data register, DMA and command execution are handled elsewhere.

The command-block byte registers for features, sector count and the three LBA bytes are each two deep. Every write pushes the current byte into a previous slot, so a host can load 48-bit parameters with two writes per register. A high-order-byte select bit in the Device Control register picks which slot is read back. The status byte is assembled from state that the core sets through a small core-side port, which can also raise an interrupt. A read of Status acknowledges that interrupt and a read of Alternate Status does not. While the device is busy, every register read returns Status.

A small host-access state machine turns each strobe into exactly one read or write event. It has three states: `HS_IDLE`, `HS_READ` and `HS_WRITE`. From `HS_IDLE` a low write strobe takes the *write-start* transition to `HS_WRITE`. Otherwise a low read strobe takes the *read-start* transition to `HS_READ`. Each access state takes its *release* transition back to `HS_IDLE` once its strobe goes high again. The event fires only on the start transition.

Top module: `ata_taskfile`

## Requirements
- R1: An access reaches a command-block register only with cs0_n=0 and cs1_n=1 and da in 1..7. It reaches the control register only with cs0_n=1, cs1_n=0 and da=6. Any other chip-select or address combination leaves host_rdata_oe at 0 on reads and changes no register on writes. Command-block map: 1 = Error (read) / Features (write), 2 = sector count, 3/4/5 = LBA low/mid/high, 6 = Device, 7 = Status (read) / Command (write).
- R2: After hard reset (rst_n=0), and while soft reset is held (Device Control bit 2 = 1), Error = 01h, sector count = 01h, LBA low/mid/high = 00h, Device = A0h and Status = 50h. The previous bytes are 00h, BSY/DRQ/ERR are 0 and no interrupt is pending.
- R3: The status byte has BSY in bit 7, DRDY in bit 6 (held at 1), DF in bit 5 (0), DSC in bit 4 (held at 1), DRQ in bit 3, CORR in bit 2 (0), IDX in bit 1 (0) and ERR in bit 0. A core_stat_we cycle loads BSY, DRQ, ERR and the Error register. Alternate Status (control block, da=6) returns the same byte.
- R4: Each write to addresses 1..5 moves the current byte into the previous slot and stores the new byte. A read of 2..5 returns the current byte when HOB (Device Control bit 7) is 0 and the previous byte when HOB is 1.
- R5: Any accepted write to a command-block register clears HOB to 0.
- R6: While BSY is 1, a read of any valid register address returns the status byte.
- R7: A core_irq_pulse sets a pending interrupt. intrq is high while an interrupt is pending and nIEN (Device Control bit 1) is 0.
- R8: A read of Status of the selected device clears the pending interrupt. A read of Alternate Status leaves it pending.
- R9: Device bit 4 (DRV) names the selected device. Writes to the Device register always take effect. Other command-block writes are ignored when DRV differs from dev_id, and reads then leave host_rdata_oe at 0.
- R10: A Command write to the selected device raises cmd_stb for exactly one cycle after the write edge, with the written byte on cmd_code.
- R11: A strobe held low for many cycles performs exactly one register update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, synchronous |
| dev_id | input | 1 | Strapped device number (0 or 1) |
| cs0_n | input | 1 | Command-block chip select, active low |
| cs1_n | input | 1 | Control-block chip select, active low |
| da | input | 3 | Register address within the selected block |
| dior_n | input | 1 | Host read strobe, active low |
| diow_n | input | 1 | Host write strobe, active low |
| host_wdata | input | REG_W | Host write byte (low data lines) |
| host_rdata | output | REG_W | Register read byte |
| host_rdata_oe | output | 1 | Drive enable for host_rdata |
| intrq | output | 1 | Interrupt request to the host |
| core_stat_we | input | 1 | Core loads BSY, DRQ, ERR and error code |
| core_bsy | input | 1 | New BSY value |
| core_drq | input | 1 | New DRQ value |
| core_err | input | 1 | New ERR value |
| core_err_code | input | REG_W | New Error register value |
| core_irq_pulse | input | 1 | One-cycle interrupt raise from the core |
| cmd_stb | output | 1 | One-cycle pulse after a Command write |
| cmd_code | output | REG_W | Last command byte |
| cmd_feature | output | 2*REG_W | Features {previous, current} |
| cmd_count | output | 2*REG_W | Sector count {previous, current} |
| cmd_lba | output | 2*NUM_LBA*REG_W | LBA {previous high..low, current high..low} |
| cmd_device | output | REG_W | Device register |

## Verification
The bench uses the default REG_W = 8 and NUM_LBA = 3. This is the only setting that fits the fixed address map, and it places every two-deep register at its real address. Across a hard reset the bench drives the dev_id strap both ways. This brings the floating-read path and the ignored-write path within reach for a DRV match and a DRV mismatch at either strap value. Long strobes, soft reset, and interrupt clears by a Status read versus an Alternate Status read are all run against a behavioural model that tracks the registers.

// File: rtl/tf_pkg.sv
package tf_pkg;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_READ  = 2'd1,
        HS_WRITE = 2'd2
    } host_state_e;

    // command block addresses
    localparam logic [2:0] A_ERRFEAT = 3'd1;
    localparam logic [2:0] A_COUNT   = 3'd2;
    localparam logic [2:0] A_DEVICE  = 3'd6;
    localparam logic [2:0] A_STATCMD = 3'd7;
    // control block address
    localparam logic [2:0] A_ALTCTL  = 3'd6;

    localparam logic [7:0] DEF_ERROR  = 8'h01;
    localparam logic [7:0] DEF_COUNT  = 8'h01;
    localparam logic [7:0] DEF_DEVICE = 8'hA0;

    // status bit positions
    localparam int ST_BSY  = 7;
    localparam int ST_DRDY = 6;
    localparam int ST_DSC  = 4;
    localparam int ST_DRQ  = 3;
    localparam int ST_ERR  = 0;

    // device control bit positions
    localparam int DC_HOB  = 7;
    localparam int DC_SRST = 2;
    localparam int DC_NIEN = 1;

    // device register bit position
    localparam int DV_DRV  = 4;

endpackage

// File: rtl/tf_host_fsm.sv
module tf_host_fsm
    import tf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic rd_evt,
    output logic wr_evt
);

    host_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE: begin
                if (!wr_n)      state_d = HS_WRITE;
                else if (!rd_n) state_d = HS_READ;
            end
            HS_WRITE: if (wr_n) state_d = HS_IDLE;
            HS_READ:  if (rd_n) state_d = HS_IDLE;
            default:  state_d = HS_IDLE;
        endcase
    end

    always_comb begin
        wr_evt = (state_q == HS_IDLE) && !wr_n;
        rd_evt = (state_q == HS_IDLE) && wr_n && !rd_n;
    end

    AST_WR_SINGLE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> !wr_evt); // R11
    AST_RD_SINGLE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_evt |=> !rd_evt); // R11

endmodule

// File: rtl/tf_dual_byte.sv
module tf_dual_byte #(
    parameter int           W        = 8,
    parameter logic [W-1:0] CUR_DEF  = '0,
    parameter logic [W-1:0] PREV_DEF = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cur  <= CUR_DEF;
            prev <= PREV_DEF;
        end else if (we) begin
            prev <= cur;
            cur  <= d;
        end
    end

    AST_PREV_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr) |=> (prev == $past(cur))); // R4

endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
    import tf_pkg::*;
#(
    parameter int REG_W   = 8,
    parameter int NUM_LBA = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       dev_id,
    input  logic                       cs0_n,
    input  logic                       cs1_n,
    input  logic [2:0]                 da,
    input  logic                       dior_n,
    input  logic                       diow_n,
    input  logic [REG_W-1:0]           host_wdata,
    output logic [REG_W-1:0]           host_rdata,
    output logic                       host_rdata_oe,
    output logic                       intrq,
    input  logic                       core_stat_we,
    input  logic                       core_bsy,
    input  logic                       core_drq,
    input  logic                       core_err,
    input  logic [REG_W-1:0]           core_err_code,
    input  logic                       core_irq_pulse,
    output logic                       cmd_stb,
    output logic [REG_W-1:0]           cmd_code,
    output logic [2*REG_W-1:0]         cmd_feature,
    output logic [2*REG_W-1:0]         cmd_count,
    output logic [2*NUM_LBA*REG_W-1:0] cmd_lba,
    output logic [REG_W-1:0]           cmd_device
);

    // features, count, then LBA bytes; slot k sits at address k+1
    localparam int NUM_SH = 2 + NUM_LBA;

    logic rd_evt, wr_evt;
    logic sel_cmd, sel_ctl, this_dev, cmd_wr, acc_wr, status_rd;
    logic hob_q, srst_q, nien_q;
    logic bsy_q, drq_q, err_q, irq_q;
    logic [REG_W-1:0] dev_q, error_q, status_byte;
    logic             cmd_stb_q;
    logic [REG_W-1:0] cmd_code_q;

    logic [REG_W-1:0] sh_cur  [NUM_SH];
    logic [REG_W-1:0] sh_prev [NUM_SH];
    logic [REG_W-1:0] sh_rd   [NUM_SH];
    logic [NUM_SH-1:0] sh_we;

    tf_host_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_n   (dior_n),
        .wr_n   (diow_n),
        .rd_evt (rd_evt),
        .wr_evt (wr_evt)
    );

    always_comb begin
        sel_cmd   = !cs0_n && cs1_n && (da != 3'd0);
        sel_ctl   = cs0_n && !cs1_n && (da == A_ALTCTL);
        this_dev  = (dev_q[DV_DRV] == dev_id);
        cmd_wr    = wr_evt && sel_cmd;
        acc_wr    = cmd_wr && (this_dev || (da == A_DEVICE));
        status_rd = rd_evt && sel_cmd && (da == A_STATCMD) && this_dev;
    end

    for (genvar k = 0; k < NUM_SH; k++) begin : g_sh
        assign sh_we[k] = cmd_wr && this_dev && (da == 3'(k + 1));
        assign sh_rd[k] = hob_q ? sh_prev[k] : sh_cur[k];
        tf_dual_byte #(
            .W       (REG_W),
            .CUR_DEF ((k == 1) ? REG_W'(DEF_COUNT) : REG_W'(0)),
            .PREV_DEF(REG_W'(0))
        ) u_byte (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (srst_q),
            .we   (sh_we[k]),
            .d    (host_wdata),
            .cur  (sh_cur[k]),
            .prev (sh_prev[k])
        );
    end

    for (genvar j = 0; j < NUM_LBA; j++) begin : g_lba_out
        assign cmd_lba[j*REG_W +: REG_W]             = sh_cur[2 + j];
        assign cmd_lba[(NUM_LBA + j)*REG_W +: REG_W] = sh_prev[2 + j];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hob_q      <= 1'b0;
            srst_q     <= 1'b0;
            nien_q     <= 1'b0;
            dev_q      <= REG_W'(DEF_DEVICE);
            bsy_q      <= 1'b0;
            drq_q      <= 1'b0;
            err_q      <= 1'b0;
            error_q    <= REG_W'(DEF_ERROR);
            irq_q      <= 1'b0;
            cmd_stb_q  <= 1'b0;
            cmd_code_q <= '0;
        end else begin
            if (wr_evt && sel_ctl) begin
                hob_q  <= host_wdata[DC_HOB];
                srst_q <= host_wdata[DC_SRST];
                nien_q <= host_wdata[DC_NIEN];
            end else if (acc_wr) begin
                hob_q  <= 1'b0;
            end
            cmd_stb_q <= cmd_wr && this_dev && (da == A_STATCMD) && !srst_q;
            if (cmd_wr && this_dev && (da == A_STATCMD))
                cmd_code_q <= host_wdata;
            if (srst_q) begin
                dev_q   <= REG_W'(DEF_DEVICE);
                bsy_q   <= 1'b0;
                drq_q   <= 1'b0;
                err_q   <= 1'b0;
                error_q <= REG_W'(DEF_ERROR);
                irq_q   <= 1'b0;
            end else begin
                if (cmd_wr && (da == A_DEVICE)) dev_q <= host_wdata;
                if (core_stat_we) begin
                    bsy_q   <= core_bsy;
                    drq_q   <= core_drq;
                    err_q   <= core_err;
                    error_q <= core_err_code;
                end
                if (core_irq_pulse)  irq_q <= 1'b1;
                else if (status_rd)  irq_q <= 1'b0;
            end
        end
    end

    always_comb begin
        status_byte          = '0;
        status_byte[ST_BSY]  = bsy_q;
        status_byte[ST_DRDY] = 1'b1;
        status_byte[ST_DSC]  = 1'b1;
        status_byte[ST_DRQ]  = drq_q;
        status_byte[ST_ERR]  = err_q;
    end

    always_comb begin
        host_rdata_oe = !dior_n && (sel_cmd || sel_ctl) && this_dev;
        host_rdata    = '0;
        if (host_rdata_oe) begin
            if (bsy_q || sel_ctl) begin
                host_rdata = status_byte;
            end else begin
                case (da)
                    A_ERRFEAT: host_rdata = error_q;
                    A_DEVICE:  host_rdata = dev_q;
                    A_STATCMD: host_rdata = status_byte;
                    default: begin
                        for (int k = 1; k < NUM_SH; k++)
                            if (da == 3'(k + 1)) host_rdata = sh_rd[k];
                    end
                endcase
            end
        end
    end

    assign intrq       = irq_q && !nien_q;
    assign cmd_stb     = cmd_stb_q;
    assign cmd_code    = cmd_code_q;
    assign cmd_device  = dev_q;
    assign cmd_feature = {sh_prev[0], sh_cur[0]};
    assign cmd_count   = {sh_prev[1], sh_cur[1]};

    AST_STATUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !core_irq_pulse && !srst_q) |=> !intrq); // R8
    AST_ALT_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && sel_ctl && !core_irq_pulse && !srst_q) |=> $stable(irq_q)); // R8
    AST_BUSY_READS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata_oe && bsy_q) |-> (host_rdata[ST_BSY] && host_rdata[ST_DRDY])); // R6
    AST_HOB_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |=> !hob_q); // R5
    AST_SRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> (error_q == REG_W'(DEF_ERROR) && dev_q == REG_W'(DEF_DEVICE)
                    && !bsy_q && !irq_q)); // R2
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(core_irq_pulse)); // R7
    AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> !cmd_stb); // R10

endmodule

// File: tb/tb_ata_taskfile.sv
`timescale 1ns/1ps
module tb_ata_taskfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dev_id = 1'b0;
    logic        cs0_n = 1'b1, cs1_n = 1'b1, dior_n = 1'b1, diow_n = 1'b1;
    logic [2:0]  da = 3'd0;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic        host_rdata_oe, intrq;
    logic        core_stat_we = 0, core_bsy = 0, core_drq = 0, core_err = 0, core_irq_pulse = 0;
    logic [7:0]  core_err_code = 8'h00;
    logic        cmd_stb;
    logic [7:0]  cmd_code, cmd_device;
    logic [15:0] cmd_feature, cmd_count;
    logic [47:0] cmd_lba;

    always #5 clk = ~clk;

    ata_taskfile dut (
        .clk(clk), .rst_n(rst_n), .dev_id(dev_id), .cs0_n(cs0_n), .cs1_n(cs1_n),
        .da(da), .dior_n(dior_n), .diow_n(diow_n), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe), .intrq(intrq),
        .core_stat_we(core_stat_we), .core_bsy(core_bsy), .core_drq(core_drq),
        .core_err(core_err), .core_err_code(core_err_code), .core_irq_pulse(core_irq_pulse),
        .cmd_stb(cmd_stb), .cmd_code(cmd_code), .cmd_feature(cmd_feature),
        .cmd_count(cmd_count), .cmd_lba(cmd_lba), .cmd_device(cmd_device)
    );

    int n_chk = 0;
    int n_err = 0;
    bit mon_on = 0;

    // behavioural model: slot 0..4 = addresses 1..5
    logic [7:0] m_cur [5];
    logic [7:0] m_prev[5];
    logic [7:0] m_dev, m_errreg, m_cmdcode;
    bit m_hob, m_srst, m_nien, m_bsy, m_drq, m_erb, m_irq, m_cmd;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic void m_defaults();
        for (int i = 0; i < 5; i++) begin
            m_cur[i]  = (i == 1) ? 8'h01 : 8'h00;
            m_prev[i] = 8'h00;
        end
        m_dev = 8'hA0; m_errreg = 8'h01;
        m_bsy = 0; m_drq = 0; m_erb = 0; m_irq = 0;
    endfunction

    function automatic logic [7:0] m_status();
        return {m_bsy, 1'b1, 1'b0, 1'b1, m_drq, 1'b0, 1'b0, m_erb};
    endfunction

    function automatic void m_read(input logic c0, input logic c1, input logic [2:0] a,
                                   output logic oe, output logic [7:0] d);
        bit cmd = !c0 && c1 && a != 3'd0;
        bit ctl = c0 && !c1 && a == 3'd6;
        oe = (cmd || ctl) && (m_dev[4] == dev_id);
        d = 8'h00;
        if (oe) begin
            if (m_bsy || ctl || a == 3'd7) d = m_status();
            else if (a == 3'd1)            d = m_errreg;
            else if (a == 3'd6)            d = m_dev;
            else d = m_hob ? m_prev[a-1] : m_cur[a-1];
        end
    endfunction

    function automatic void m_write(input logic c0, input logic c1, input logic [2:0] a,
                                    input logic [7:0] d);
        if (c0 && !c1 && a == 3'd6) begin
            m_hob = d[7]; m_srst = d[2]; m_nien = d[1];
        end else if (!c0 && c1 && a != 3'd0) begin
            if (a == 3'd6) begin
                m_dev = d; m_hob = 0;
            end else if (m_dev[4] == dev_id) begin
                m_hob = 0;
                if (a <= 3'd5) begin
                    m_prev[a-1] = m_cur[a-1];
                    m_cur[a-1]  = d;
                end else begin
                    m_cmd = 1; m_cmdcode = d;
                end
            end
        end
    endfunction

    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            chk("R7 intrq", {63'd0, intrq}, {63'd0, m_irq & ~m_nien});
            chk("R10 cmd_stb", {63'd0, cmd_stb}, {63'd0, m_cmd});
            if (m_cmd) chk("R10 cmd_code", {56'd0, cmd_code}, {56'd0, m_cmdcode});
        end
    end

    task automatic hard_reset(input logic strap);
        @(negedge clk);
        rst_n = 0; dev_id = strap;
        repeat (2) @(negedge clk);
        m_defaults();
        m_hob = 0; m_srst = 0; m_nien = 0; m_cmd = 0; m_cmdcode = 8'h00;
        rst_n = 1;
    endtask

    task automatic host_wr(input logic c0, input logic c1, input logic [2:0] a,
                           input logic [7:0] d, input int hold);
        @(negedge clk);
        cs0_n = c0; cs1_n = c1; da = a; host_wdata = d; diow_n = 0;
        @(posedge clk); #1 m_write(c0, c1, a, d);
        @(posedge clk); #1 m_cmd = 0; if (m_srst) m_defaults();
        repeat (hold - 1) @(posedge clk);
        @(negedge clk);
        diow_n = 1; cs0_n = 1; cs1_n = 1;
    endtask

    task automatic host_rd(input logic c0, input logic c1, input logic [2:0] a,
                           output logic oe, output logic [7:0] d);
        @(negedge clk);
        cs0_n = c0; cs1_n = c1; da = a; dior_n = 0;
        #2 oe = host_rdata_oe; d = host_rdata;
        @(posedge clk); #1
        if (!c0 && c1 && a == 3'd7 && m_dev[4] == dev_id) m_irq = 0;
        @(negedge clk);
        dior_n = 1; cs0_n = 1; cs1_n = 1;
    endtask

    task automatic rd_chk(input string req, input logic c0, input logic c1, input logic [2:0] a);
        logic moe, oe;
        logic [7:0] md, d;
        m_read(c0, c1, a, moe, md);
        host_rd(c0, c1, a, oe, d);
        chk({req, " oe"}, {63'd0, oe}, {63'd0, moe});
        if (moe) chk({req, " data"}, {56'd0, d}, {56'd0, md});
    endtask

    task automatic rd_exp(input string req, input logic c0, input logic c1, input logic [2:0] a,
                          input logic [7:0] exp);
        logic oe;
        logic [7:0] d;
        host_rd(c0, c1, a, oe, d);
        chk({req, " oe"}, {63'd0, oe}, 64'd1);
        chk({req, " data"}, {56'd0, d}, {56'd0, exp});
    endtask

    task automatic core_op(input logic we, input logic b, input logic q, input logic e,
                           input logic [7:0] code, input logic irq);
        @(negedge clk);
        core_stat_we = we; core_bsy = b; core_drq = q; core_err = e;
        core_err_code = code; core_irq_pulse = irq;
        @(posedge clk); #1
        if (we) begin m_bsy = b; m_drq = q; m_erb = e; m_errreg = code; end
        if (irq) m_irq = 1;
        @(negedge clk);
        core_stat_we = 0; core_irq_pulse = 0;
    endtask

    initial begin
        #(200000 * 10);
        n_err++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic oe;
        logic [7:0] d;
        hard_reset(1'b0);
        mon_on = 1;

        // R2 reset values
        rd_exp("R2 error",  0, 1, 3'd1, 8'h01);
        rd_exp("R2 count",  0, 1, 3'd2, 8'h01);
        rd_exp("R2 lba_lo", 0, 1, 3'd3, 8'h00);
        rd_exp("R2 lba_mid",0, 1, 3'd4, 8'h00);
        rd_exp("R2 lba_hi", 0, 1, 3'd5, 8'h00);
        rd_exp("R2 device", 0, 1, 3'd6, 8'hA0);
        rd_exp("R2 status", 0, 1, 3'd7, 8'h50);
        rd_exp("R2 alt",    1, 0, 3'd6, 8'h50);

        // R4 two-deep registers, HOB select
        for (int a = 2; a <= 5; a++) begin
            host_wr(0, 1, 3'(a), 8'(8'h10 + a), 1);
            host_wr(0, 1, 3'(a), 8'(8'hC0 + a), 1);
        end
        for (int a = 2; a <= 5; a++) rd_exp("R4 cur", 0, 1, 3'(a), 8'(8'hC0 + a));
        host_wr(1, 0, 3'd6, 8'h80, 1);
        for (int a = 2; a <= 5; a++) rd_exp("R4 prev", 0, 1, 3'(a), 8'(8'h10 + a));
        rd_chk("R4 device under hob", 0, 1, 3'd6);
        // R5 command-block write clears HOB
        host_wr(0, 1, 3'd1, 8'h5A, 1);
        rd_exp("R5 hob cleared", 0, 1, 3'd3, 8'hC3);

        // R1 decode
        host_rd(0, 0, 3'd2, oe, d); chk("R1 both cs oe", {63'd0, oe}, 64'd0);
        host_rd(1, 0, 3'd2, oe, d); chk("R1 ctl addr2 oe", {63'd0, oe}, 64'd0);
        host_rd(0, 1, 3'd0, oe, d); chk("R1 data reg oe", {63'd0, oe}, 64'd0);
        host_wr(1, 0, 3'd2, 8'h80, 1);
        rd_exp("R1 stray ctl write ignored", 0, 1, 3'd2, 8'hC2);

        // R11 long strobe: one shift only
        host_wr(0, 1, 3'd2, 8'h3C, 4);
        rd_exp("R11 cur", 0, 1, 3'd2, 8'h3C);
        host_wr(1, 0, 3'd6, 8'h80, 1);
        rd_exp("R11 prev", 0, 1, 3'd2, 8'hC2);
        host_wr(1, 0, 3'd6, 8'h00, 1);

        // R3 status layout and core update
        core_op(1, 0, 1, 1, 8'h04, 0);
        rd_exp("R3 status", 0, 1, 3'd7, 8'h59);
        rd_exp("R3 alt",    1, 0, 3'd6, 8'h59);
        rd_exp("R3 error",  0, 1, 3'd1, 8'h04);

        // R6 busy returns status
        core_op(1, 1, 0, 0, 8'h00, 0);
        rd_exp("R6 count while busy", 0, 1, 3'd2, 8'hD0);
        rd_exp("R6 device while busy", 0, 1, 3'd6, 8'hD0);
        core_op(1, 0, 0, 0, 8'h00, 0);
        rd_chk("R6 count after busy", 0, 1, 3'd2);

        // R7 / R8 interrupt
        core_op(0, 0, 0, 0, 8'h00, 1);
        chk("R7 intrq set", {63'd0, intrq}, 64'd1);
        host_wr(1, 0, 3'd6, 8'h02, 1);
        chk("R7 masked", {63'd0, intrq}, 64'd0);
        host_wr(1, 0, 3'd6, 8'h00, 1);
        chk("R7 unmasked", {63'd0, intrq}, 64'd1);
        rd_chk("R8 alt read", 1, 0, 3'd6);
        chk("R8 alt keeps irq", {63'd0, intrq}, 64'd1);
        rd_chk("R8 status read", 0, 1, 3'd7);
        chk("R8 status clears irq", {63'd0, intrq}, 64'd0);

        // R10 command strobe and captured parameters
        host_wr(0, 1, 3'd7, 8'h25, 1);
        chk("R10 cmd_lba", {16'd0, cmd_lba},
            {16'd0, m_prev[4], m_prev[3], m_prev[2], m_cur[4], m_cur[3], m_cur[2]});
        chk("R10 cmd_count", {48'd0, cmd_count}, {48'd0, m_prev[1], m_cur[1]});

        // R9 other device selected
        host_wr(0, 1, 3'd6, 8'hB0, 1);
        host_rd(0, 1, 3'd2, oe, d); chk("R9 float read", {63'd0, oe}, 64'd0);
        host_wr(0, 1, 3'd2, 8'h77, 1);
        host_wr(0, 1, 3'd7, 8'hEC, 1);
        host_wr(0, 1, 3'd6, 8'hE0, 1);
        rd_exp("R9 write ignored", 0, 1, 3'd2, 8'h3C);

        // R2 soft reset
        core_op(1, 0, 1, 1, 8'h10, 1);
        host_wr(1, 0, 3'd6, 8'h04, 1);
        host_wr(1, 0, 3'd6, 8'h00, 1);
        chk("R2 srst intrq", {63'd0, intrq}, 64'd0);
        rd_exp("R2 srst count", 0, 1, 3'd2, 8'h01);
        rd_exp("R2 srst error", 0, 1, 3'd1, 8'h01);
        rd_exp("R2 srst status", 0, 1, 3'd7, 8'h50);
        rd_exp("R2 srst device", 0, 1, 3'd6, 8'hA0);
        host_wr(1, 0, 3'd6, 8'h80, 1);
        rd_exp("R2 srst prev", 0, 1, 3'd3, 8'h00);
        host_wr(1, 0, 3'd6, 8'h00, 1);

        // R9 with strap = 1
        hard_reset(1'b1);
        host_rd(0, 1, 3'd7, oe, d); chk("R9 strap1 float", {63'd0, oe}, 64'd0);
        host_wr(0, 1, 3'd3, 8'h99, 1);
        host_wr(0, 1, 3'd6, 8'hF0, 1);
        rd_exp("R9 strap1 ignored", 0, 1, 3'd3, 8'h00);
        host_wr(0, 1, 3'd3, 8'h42, 1);
        rd_exp("R9 strap1 accepted", 0, 1, 3'd3, 8'h42);
        rd_chk("R9 strap1 device", 0, 1, 3'd6);

        mon_on = 0;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule